// File: doc/BRIEF.md
# GPIO Controller with Grouped Pull Control

This block is a register-mapped general-purpose I/O controller for eight 8-bit ports. The ports come in three kinds. Per-pin ports have one direction bit for each pin. Whole-port ports use a single direction bit that sets all eight pins together. The input-only port has no direction control and never drives.

Every port with outputs keeps an output latch. Reading a port's data address returns the latch on pins that drive and the synchronized pad level on pins that do not. Two pull registers switch weak pull resistors on for fixed groups of pins, such as whole ports, nibbles or pin pairs. The block reports the result as a per-pin pull-enable and a per-pin pull-polarity output. A pin that drives never has its pull enabled.

The register bus is a simple synchronous one. A write takes effect at the clock edge where wrEn is high. rdData is a combinational function of addr and the current register state.

Top module: `gpio_pull_top`

## Requirements
- R1: After reset every latch, direction and pull register is 0. No pin drives, no pull is enabled, and every register address reads 0 while the pads are low.
- R2: The data register of port p is at address 2p and its direction register is at 2p+1. On per-pin ports (2, 4, 5, 6, 7), direction bit b = 1 drives pin b (padOe) with latch bit b (padOut), and 0 leaves it undriven.
- R3: Ports 0 and 1 take their direction from bit 0 alone, and that bit drives all eight pins. Direction bits 1 to 7 of these ports are ignored and read back as 0.
- R4: A data read returns the latch bit for a driving pin and the synchronized pad bit for a non-driving pin.
- R5: A write to the data register of a non-driving pin changes only its latch. The pin stays undriven, and the new value appears once the pin is made an output.
- R6: Port 3 and pin 0 of port 4 never drive. Their direction bits read as 0, and their data bits always read the pad.
- R7: Pull register A is at address 0x16 and only bits 0 to 4 are used. Bit 0 controls port 0 (pull-down), bit 1 controls port 1 (pull-down), bit 2 controls port 2 (pull-up), bit 3 controls pins 4 to 7 of port 3 (pull-down), and bit 4 controls pins 0 and 1 of port 7 (pull-up). A value of 1 enables the pull.
- R8: Pull register B is at address 0x17 and only bits 0 to 5 are used. The bits enable pull-ups on these groups: bit 0 on port 4 pins 1 to 3, bit 1 on port 4 pins 4 to 7, bit 2 on port 5 pins 0 to 3, bit 3 on port 5 pins 4 to 7, bit 4 on port 6 pins 0 to 3, and bit 5 on port 6 pins 4 to 7. pullUp is 1 on every pull-up pin and 0 on every other pin.
- R9: pullEn is 0 on any pin whose padOe is 1, whatever the pull registers hold.
- R10: Unused pull-register bits read as 0, and any unmapped address (0x10 to 0x15, 0x18 to 0x1F) reads 0.
- R11: A pad change that occurs between two clock edges first shows on a data read after the second of the following edges, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | 5 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdData | output | 8 | Read data for addr |
| padIn | input | 64 | Pad levels, pin b of port p at bit 8p+b |
| padOut | output | 64 | Output latch value per pin |
| padOe | output | 64 | Drive enable per pin |
| pullEn | output | 64 | Weak pull enable per pin |
| pullUp | output | 64 | Pull polarity per pin, 1 = up |

## Verification
The assertions check on every cycle the following properties. A direction write sets the drive enables it should on per-pin and whole-port ports. A latch holds unless its own port is written. A read of a driving pin returns the latch. The synchronized pad lags the pad by exactly two edges. Only the bench's scenarios can show that the pull groups sit on the right pins with the right polarity, that pulls are suppressed on driving pins, and that input-only pins ignore direction writes. The scenarios also cover the read-back of unused bits and unmapped addresses, and the point at which a latch written while a pin is an input appears on the pad.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NPORT  = 8;
  localparam int PW     = 8;
  localparam int NPIN   = NPORT * PW;
  localparam int AW     = 5;
  localparam int PULLA_W = 5;
  localparam int PULLB_W = 6;
  localparam logic [AW-1:0] PULLA_ADDR = 5'h16;
  localparam logic [AW-1:0] PULLB_ADDR = 5'h17;

  typedef enum logic [1:0] {KIND_PIN, KIND_WHOLE, KIND_IN} kind_e;

  function automatic kind_e portKind(input int p);
    if (p == 0 || p == 1) return KIND_WHOLE;
    if (p == 3) return KIND_IN;
    return KIND_PIN;
  endfunction

  function automatic logic [PW-1:0] dirMask(input int p);
    case (portKind(p))
      KIND_WHOLE: return 8'h01;
      KIND_IN:    return 8'h00;
      default:    return (p == 4) ? 8'hFE : 8'hFF;
    endcase
  endfunction

  // Polarity of each pin's pull resistor (1 = up); pins without pull are 0.
  localparam logic [NPIN-1:0] PULL_UP_MAP = 64'h03FF_FFFE_00FF_0000;

  typedef struct packed {
    logic [NPORT-1:0] latchWr;
    logic [NPORT-1:0] dirWr;
    logic             pullAWr;
    logic             pullBWr;
    logic [NPORT-1:0] latchRd;
    logic [NPORT-1:0] dirRd;
    logic             pullARd;
    logic             pullBRd;
  } strobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = AW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (addr == ADDR_W'(2 * p)) begin
        stb.latchRd[p] = 1'b1;
        stb.latchWr[p] = wrEn;
      end
      if (addr == ADDR_W'(2 * p + 1)) begin
        stb.dirRd[p] = 1'b1;
        stb.dirWr[p] = wrEn;
      end
    end
    if (addr == ADDR_W'(PULLA_ADDR)) begin
      stb.pullARd = 1'b1;
      stb.pullAWr = wrEn;
    end
    if (addr == ADDR_W'(PULLB_ADDR)) begin
      stb.pullBRd = 1'b1;
      stb.pullBWr = wrEn;
    end
  end
endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [PW-1:0]   wrData,
  input  logic [NPIN-1:0] padIn,
  output logic [PW-1:0]   rdData,
  output logic [NPIN-1:0] padOut,
  output logic [NPIN-1:0] padOe,
  output logic [NPIN-1:0] pullEn,
  output logic [NPIN-1:0] pullUp
);
  logic [NPORT-1:0][PW-1:0] latchQ;
  logic [NPORT-1:0][PW-1:0] dirQ;
  logic [NPORT-1:0][PW-1:0] oeV;
  logic [NPORT-1:0][PW-1:0] portRd;
  logic [NPIN-1:0]          syncA;
  logic [NPIN-1:0]          syncB;
  logic [PULLA_W-1:0]       pullAQ;
  logic [PULLB_W-1:0]       pullBQ;
  logic [NPIN-1:0]          grpEn;
  logic [1:0]               sinceRst;

  // Two-flop pad synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      sinceRst <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
    end
  end

  AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (syncB == $past(padIn, 2))); // R11

  for (genvar p = 0; p < NPORT; p++) begin : gPort
    always_ff @(posedge clk) begin
      if (!rstN) begin
        latchQ[p] <= '0;
        dirQ[p]   <= '0;
      end else begin
        if (stb.latchWr[p]) latchQ[p] <= wrData;
        if (stb.dirWr[p])   dirQ[p]   <= wrData & dirMask(p);
      end
    end

    if (portKind(p) == KIND_WHOLE) begin : gWhole
      assign oeV[p] = {PW{dirQ[p][0]}};
      AST_DIR_WHOLE: assert property (@(posedge clk) disable iff (!rstN)
        stb.dirWr[p] |=> (oeV[p] == {PW{$past(wrData[0])}})); // R3
    end else if (portKind(p) == KIND_IN) begin : gIn
      assign oeV[p] = '0;
    end else begin : gPin
      assign oeV[p] = dirQ[p];
      AST_DIR_PIN: assert property (@(posedge clk) disable iff (!rstN)
        stb.dirWr[p] |=> (oeV[p] == ($past(wrData) & dirMask(p)))); // R2
    end

    assign portRd[p] = (latchQ[p] & oeV[p]) | (syncB[p*PW +: PW] & ~oeV[p]);

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !stb.latchWr[p] |=> $stable(latchQ[p])); // R5
    AST_OUT_READ: assert property (@(posedge clk) disable iff (!rstN)
      stb.latchRd[p] |-> (((rdData ^ latchQ[p]) & oeV[p]) == '0)); // R4
  end

  // Pull registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pullAQ <= '0;
      pullBQ <= '0;
    end else begin
      if (stb.pullAWr) pullAQ <= wrData[PULLA_W-1:0];
      if (stb.pullBWr) pullBQ <= wrData[PULLB_W-1:0];
    end
  end

  // Group map: which pull bit covers which pins
  always_comb begin
    grpEn = '0;
    grpEn[0*PW +: PW]     = {PW{pullAQ[0]}};
    grpEn[1*PW +: PW]     = {PW{pullAQ[1]}};
    grpEn[2*PW +: PW]     = {PW{pullAQ[2]}};
    grpEn[3*PW+4 +: 4]    = {4{pullAQ[3]}};
    grpEn[7*PW +: 2]      = {2{pullAQ[4]}};
    grpEn[4*PW+1 +: 3]    = {3{pullBQ[0]}};
    grpEn[4*PW+4 +: 4]    = {4{pullBQ[1]}};
    grpEn[5*PW +: 4]      = {4{pullBQ[2]}};
    grpEn[5*PW+4 +: 4]    = {4{pullBQ[3]}};
    grpEn[6*PW +: 4]      = {4{pullBQ[4]}};
    grpEn[6*PW+4 +: 4]    = {4{pullBQ[5]}};
  end

  assign padOut = latchQ;
  assign padOe  = oeV;
  assign pullEn = grpEn & ~padOe;
  assign pullUp = PULL_UP_MAP;

  // Read-back mux
  always_comb begin
    rdData = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (stb.latchRd[p]) rdData = rdData | portRd[p];
      if (stb.dirRd[p])   rdData = rdData | dirQ[p];
    end
    if (stb.pullARd) rdData = rdData | PW'(pullAQ);
    if (stb.pullBRd) rdData = rdData | PW'(pullBQ);
  end
endmodule

// File: rtl/gpio_pull_top.sv
module gpio_pull_top
  import gpio_pkg::*;
#(
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PW-1:0]     wrData,
  input  logic              wrEn,
  output logic [PW-1:0]     rdData,
  input  logic [NPIN-1:0]   padIn,
  output logic [NPIN-1:0]   padOut,
  output logic [NPIN-1:0]   padOe,
  output logic [NPIN-1:0]   pullEn,
  output logic [NPIN-1:0]   pullUp
);
  strobe_t stb;

  gpio_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .addr (addr),
    .wrEn (wrEn),
    .stb  (stb)
  );

  gpio_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .padIn  (padIn),
    .rdData (rdData),
    .padOut (padOut),
    .padOe  (padOe),
    .pullEn (pullEn),
    .pullUp (pullUp)
  );
endmodule

// File: tb/tb_gpio_pull_top.sv
module tb_gpio_pull_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  addr;
  logic [7:0]  wrData;
  logic        wrEn;
  logic [7:0]  rdData;
  logic [63:0] padIn;
  logic [63:0] padOut, padOe, pullEn, pullUp;

  gpio_pull_top dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .pullEn(pullEn), .pullUp(pullUp)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // kind: 0 rdData, 1 padOe, 2 pullEn, 3 pullUp, 4 padOut
  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    nVec  = 0;
  int    nFail = 0;
  bit    done  = 1'b0;

  task automatic push(input int kind, input logic [63:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    push(0, {56'd0, exp}, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      while (sbq.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = {56'd0, rdData};
          1: act = padOe;
          2: act = pullEn;
          3: act = pullUp;
          default: act = padOut;
        endcase
        nVec++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; addr = '0; wrData = '0; wrEn = 1'b0; padIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 24; a++) rd(5'(a), 8'h00, "R1 reset read");
    push(1, 64'h0, "R1 reset padOe");
    push(2, 64'h0, "R1 reset pullEn");
    push(3, 64'h03FF_FFFE_00FF_0000, "R8 pull polarity map");

    // Pads: P1=0F, P2=FF, P3=9C, P4=01, P6=33
    padIn = 64'h0033_0001_9CFF_0F00;
    repeat (2) @(negedge clk);

    // R2: per-pin direction on port 2
    wr(5'h05, 8'hA5);
    wr(5'h04, 8'h3C);
    push(1, 64'h0000_0000_00A5_0000, "R2 per-pin oe");
    rd(5'h05, 8'hA5, "R2 dir readback");
    rd(5'h04, 8'h7E, "R4 mixed read latch/pad");

    // R3: whole-port direction on port 0
    wr(5'h01, 8'hFE);
    rd(5'h01, 8'h00, "R3 upper dir bits ignored");
    push(1, 64'h0000_0000_00A5_0000, "R3 bit0 clear no drive");
    wr(5'h01, 8'hFF);
    rd(5'h01, 8'h01, "R3 dir reads bit0 only");
    push(1, 64'h0000_0000_00A5_00FF, "R3 whole port drives");
    wr(5'h00, 8'h96);
    rd(5'h00, 8'h96, "R4 output read is latch");

    // R5: latch write while input
    wr(5'h02, 8'h5A);
    rd(5'h02, 8'h0F, "R5 input pin still reads pad");
    push(1, 64'h0000_0000_00A5_00FF, "R5 oe unchanged");
    wr(5'h03, 8'h01);
    rd(5'h02, 8'h5A, "R5 latch appears on output");
    push(4, 64'h0000_0000_003C_5A96, "R5 padOut latches");

    // R6: input-only port 3 and port 4 pin 0
    wr(5'h07, 8'hFF);
    rd(5'h07, 8'h00, "R6 port3 dir reads 0");
    rd(5'h06, 8'h9C, "R6 port3 reads pad");
    wr(5'h09, 8'hFF);
    rd(5'h09, 8'hFE, "R6 port4 pin0 dir reads 0");
    push(1, 64'h0000_00FE_00A5_FFFF, "R6 no drive on input-only pins");
    rd(5'h08, 8'h01, "R6 port4 pin0 reads pad");

    // R7/R8/R9/R10: pulls
    wr(5'h16, 8'hFF);
    wr(5'h17, 8'hFF);
    rd(5'h16, 8'h1F, "R10 pullA unused bits 0");
    rd(5'h17, 8'h3F, "R10 pullB unused bits 0");
    push(2, 64'h03FF_FF00_F05A_0000, "R9 pulls masked on driving pins");
    wr(5'h09, 8'h00);
    wr(5'h16, 8'h00);
    wr(5'h17, 8'h01);
    push(2, 64'h0000_000E_0000_0000, "R8 B bit0 port4 pins1-3");
    wr(5'h17, 8'h02);
    push(2, 64'h0000_00F0_0000_0000, "R8 B bit1 port4 pins4-7");
    wr(5'h17, 8'h04);
    push(2, 64'h0000_0F00_0000_0000, "R8 B bit2 port5 low");
    wr(5'h17, 8'h20);
    push(2, 64'h00F0_0000_0000_0000, "R8 B bit5 port6 high");
    wr(5'h17, 8'h00);
    wr(5'h16, 8'h10);
    push(2, 64'h0300_0000_0000_0000, "R7 A bit4 port7 pins0-1");
    wr(5'h16, 8'h08);
    push(2, 64'h0000_0000_F000_0000, "R7 A bit3 port3 high");
    wr(5'h16, 8'h04);
    push(2, 64'h0000_0000_005A_0000, "R7 R9 A bit2 port2 inputs only");
    wr(5'h16, 8'h01);
    push(2, 64'h0, "R7 R9 A bit0 port0 driving");
    wr(5'h01, 8'h00);
    push(2, 64'h0000_0000_0000_00FF, "R7 A bit0 port0 input");

    // R10: unmapped addresses
    rd(5'h10, 8'h00, "R10 unmapped 0x10");
    rd(5'h15, 8'h00, "R10 unmapped 0x15");
    rd(5'h18, 8'h00, "R10 unmapped 0x18");
    rd(5'h1F, 8'h00, "R10 unmapped 0x1F");

    // R11: synchronizer latency on port 6
    addr = 5'h0C;
    padIn[55:48] = 8'hC4;
    push(0, 64'h33, "R11 not visible after one edge");
    push(0, 64'hC4, "R11 visible after two edges");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule